// File: doc/BRIEF.md
# Strobe-Modulated Step Accumulator

This block keeps an 8-bit running value that moves by one of two fixed amounts on every rising edge of its clock. An internal divide-by-4 strobe picks the amount. On three edges out of four the value rises by 3. On the fourth edge the strobe is active, and the value falls by 5 instead. The output is therefore a sawtooth that climbs by a net 4 every four edges. The arithmetic wraps modulo 256 and never saturates.

The block can serve as a deterministic test pattern source, or as an example of a datapath whose step is chosen by a derived strobe rather than fixed. It has one control input, a synchronous active-high reset. Reset returns both the value and the strobe phase to their start.

Top module: `step_accum`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 and the strobe phase restarts. The first rising edge with `rst` low therefore adds 3.
- R2: On a rising edge with `rst` low and the strobe inactive, `count` becomes (`count` + 3) mod 256.
- R3: On a rising edge with `rst` low and the strobe active, `count` becomes (`count` − 5) mod 256.
- R4: The strobe is active on exactly one edge in every four. The first active edge is the fourth edge after reset is released.
- R5: Starting from reset, `count` reads 0, 3, 6, 9, 4, 7, 10, 13, 8, 11, 14, 17, 12 after 0 through 12 edges.
- R6: The value wraps modulo 256 in both directions and does not saturate.
- R7: A reset applied partway through a group of four restarts the sequence at 0, 3, 6, 9, 4.
- R8: Across any four consecutive edges without reset, `count` changes by exactly +4 mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| count | output | 8 | Accumulated value |

## Verification
Every result is due one rising edge after the conditions that produce it. The value reflects reset, a +3 step or a −5 step one edge after `rst` and the strobe phase are sampled. Reset is driven on the falling edge, and the output is compared on the falling edge against a behavioural model that advances on each rising edge. This keeps every comparison half a cycle away from any register update. The group-of-four checks (R4, R8) compare values taken four falling edges apart. The mid-run reset case checks the value one falling edge after `rst` is raised.

// File: rtl/step_accum_pkg.sv
package step_accum_pkg;

  // One-hot step selection from control to datapath.
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepSel_t;

endpackage

// File: rtl/step_accum_ctrl.sv
module step_accum_ctrl
  import step_accum_pkg::*;
#(
  parameter int PERIOD = 4
) (
  input  logic     clk,
  input  logic     rst,
  output stepSel_t stepSel
);
  localparam int PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase;
  logic          strobe;

  assign strobe = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst)         phase <= '0;
    else if (strobe) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  always_comb begin
    stepSel.stepDown = strobe;
    stepSel.stepUp   = ~strobe;
  end

  // R4: after an active strobe the next edge is an ordinary one
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    stepSel.stepDown |=> !stepSel.stepDown);

  // R4: exactly one step kind is chosen each cycle
  a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
    $countones({stepSel.stepUp, stepSel.stepDown}) == 1);

  // R1: reset restarts the phase, so the following edge is an up step
  a_r1_phase_restart: assert property (@(posedge clk)
    rst |=> stepSel.stepUp);

endmodule

// File: rtl/step_accum_dp.sv
module step_accum_dp
  import step_accum_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int UP_STEP   = 3,
  parameter int DOWN_STEP = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  stepSel_t         stepSel,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] UP_W   = WIDTH'(UP_STEP);
  localparam logic [WIDTH-1:0] DOWN_W = WIDTH'(DOWN_STEP);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    if (stepSel.stepDown) countNext = count - DOWN_W;
    else                  countNext = count + UP_W;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= countNext;
  end

  // R1: reset clears the value
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (count == '0));

  // R2: ordinary edge adds the up step modulo 2^WIDTH
  a_r2_add_step: assert property (@(posedge clk) disable iff (rst)
    stepSel.stepUp |=> (count == WIDTH'($past(count) + UP_W)));

  // R3: strobe edge subtracts the down step modulo 2^WIDTH
  a_r3_sub_step: assert property (@(posedge clk) disable iff (rst)
    stepSel.stepDown |=> (count == WIDTH'($past(count) - DOWN_W)));

endmodule

// File: rtl/step_accum.sv
module step_accum
  import step_accum_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PERIOD    = 4,
  parameter int UP_STEP   = 3,
  parameter int DOWN_STEP = 5
) (
  input  logic             clk,
  input  logic             rst,
  output logic [7:0]       count
);
  stepSel_t   stepSel;
  logic [WIDTH-1:0] accVal;

  step_accum_ctrl #(.PERIOD(PERIOD)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .stepSel (stepSel)
  );

  step_accum_dp #(
    .WIDTH     (WIDTH),
    .UP_STEP   (UP_STEP),
    .DOWN_STEP (DOWN_STEP)
  ) uDp (
    .clk     (clk),
    .rst     (rst),
    .stepSel (stepSel),
    .count   (accVal)
  );

  assign count = 8'(accVal);

endmodule

// File: tb/sim_step_accum.sv
`timescale 1ns/1ps
module sim_step_accum;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  int modelCount = 0;
  int modelPhase = 0;

  step_accum u0 (.clk(clk), .rst(rst), .count(count));

  always #5 clk = ~clk;

  // Behavioural reference: advances on every rising edge.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      modelCount = 0;
      modelPhase = 0;
    end else if (modelPhase == 3) begin
      modelCount = (modelCount + 256 - 5) % 256;
      modelPhase = 0;
    end else begin
      modelCount = (modelCount + 3) % 256;
      modelPhase = modelPhase + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Continuous comparison with the model (R2/R3/R6 over long runs).
  always @(negedge clk) begin
    if (running && !done) check("R6 model", int'(count), modelCount);
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int seq[13] = '{0, 3, 6, 9, 4, 7, 10, 13, 8, 11, 14, 17, 12};
    int prev;
    int grp;
    bit wrapped;
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(count), 0);
    rst = 1'b0;
    running = 1'b1;
    check("R5 step 0", int'(count), seq[0]);
    for (int k = 1; k < 13; k++) begin
      prev = int'(count);
      @(negedge clk);
      check("R5 sequence", int'(count), seq[k]);
      if (k % 4 == 0) check("R3 strobe step", int'(count), (prev + 256 - 5) % 256);
      else            check("R2 plain step", int'(count), (prev + 3) % 256);
      if (k == 4) check("R4 first strobe on fourth edge", int'(count) - prev, -5);
    end
    // R8 net change over groups of four, and long run for R6 wrap
    wrapped = 1'b0;
    for (int g = 0; g < 80; g++) begin
      grp = int'(count);
      for (int j = 0; j < 4; j++) begin
        prev = int'(count);
        @(negedge clk);
        if (int'(count) < prev && prev - int'(count) != 5) begin
          wrapped = 1'b1;
          check("R6 wrap up", int'(count), (prev + 3) % 256);
        end
      end
      check("R8 net four", int'(count), (grp + 4) % 256);
    end
    check("R6 wrap seen", int'(wrapped), 1);
    // R7 mid-group reset
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset mid-run", int'(count), 0);
    rst = 1'b0;
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      check("R7 restart sequence", int'(count), seq[k]);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule